// File: doc/BRIEF.md
# Reservation Station Bank with Fixed-Latency Execution Unit

This block sits behind the dispatch stage of an out-of-order core. It holds a small set of reservation stations that all feed one functional unit, and it includes that unit. The unit is not pipelined. Dispatch writes an instruction into the bank through an allocation port. Each source operand arrives either with its value or with the tag of the station that will produce it. The bank watches two result broadcast buses, one driven by the adder bank and one by the multiplier bank. When a waiting operand's tag appears on either bus, the station captures that value.

A station whose two operands are both present is ready. When the unit is free, it takes the ready station that was dispatched earliest. It runs that station for a fixed number of execution cycles. It then drives the result and the station's tag onto its own writeback bus for one cycle and releases the station. One parameter picks the operation: a 16-bit wrapping add with a latency of two cycles, or a 16-bit multiply that keeps the low half, with a latency of three cycles. A separate parameter gives the first tag value owned by the bank.

Top module: `rs_bank_unit`

## Requirements
- R1: After reset, no writeback is driven, `allocReady` is 1 and `allocTag` equals the bank's base tag.
- R2: An allocation always fills the lowest-numbered free station. `allocTag` shows that station's tag, which is the base tag plus its index. When every station is occupied, `allocReady` is 0 and a request on `allocValid` is ignored.
- R3: The writeback carries the tag of the station that produced the result. An instruction whose two operands are valid at allocation in cycle d starts execution in cycle d+1.
- R4: `wbValid` is high for exactly one cycle, and that cycle comes LATENCY cycles after the first execution cycle: 2 for add, 3 for multiply.
- R5: The unit is not pipelined. The next operation starts no earlier than the cycle after the previous writeback, so writebacks are at least LATENCY+1 cycles apart.
- R6: When several stations are ready in the same cycle, the one dispatched earliest issues first, whatever its station index.
- R7: A waiting operand captures the value from either bus when the bus is valid and its tag matches. The instruction may then start execution in the cycle after that broadcast.
- R8: Broadcasts on both buses in the same cycle are both captured, one by each operand that waits on them.
- R9: A broadcast in the same cycle as the allocation that waits on its tag is captured into the new station.
- R10: A station is free again in the cycle after its writeback. During the writeback cycle it still counts as occupied.
- R11: A broadcast whose tag matches no waiting operand changes nothing. The waiting instruction does not execute.
- R12: Add results wrap modulo 2^16, and multiply results are the low 16 bits of the product (for example, 0xFFFF+2 gives 1, and 300*300 gives 24464).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Dispatch requests a station this cycle |
| allocAValid | input | 1 | Operand A value is present |
| allocATag | input | TAG_W | Producer tag for operand A when its value is absent |
| allocAValue | input | DATA_W | Operand A value |
| allocBValid | input | 1 | Operand B value is present |
| allocBTag | input | TAG_W | Producer tag for operand B when its value is absent |
| allocBValue | input | DATA_W | Operand B value |
| allocReady | output | 1 | At least one station is free |
| allocTag | output | TAG_W | Tag of the station the next allocation will take |
| bus0Valid | input | 1 | Adder result broadcast is valid |
| bus0Tag | input | TAG_W | Adder result tag |
| bus0Value | input | DATA_W | Adder result value |
| bus1Valid | input | 1 | Multiplier result broadcast is valid |
| bus1Tag | input | TAG_W | Multiplier result tag |
| bus1Value | input | DATA_W | Multiplier result value |
| wbValid | output | 1 | This unit's result is valid |
| wbTag | output | TAG_W | Tag of the station that produced the result |
| wbValue | output | DATA_W | Result value |

## Verification
If both operands are present at allocation in cycle d, the writeback comes in cycle d+1+LATENCY: d+3 for the adder and d+4 for the multiplier. If the last missing operand is broadcast in cycle w, the writeback comes in cycle w+1+LATENCY. If another operation is queued behind the current one, its writeback comes LATENCY+1 cycles after the previous writeback. The bench advances one cycle at a time from a fixed reference cycle. It checks that `wbValid` stays low in every cycle before the expected one, and it checks the tag and value in the expected cycle itself, so an early, late or repeated result is caught. The free state of a released station is checked in the writeback cycle and again in the cycle after it.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  // Operation performed by the bank's functional unit.
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } rsuOp_e;

  // Strobes from control to datapath, all for the current cycle.
  typedef struct packed {
    logic allocFire;   // write the allocation port into the chosen station
    logic issueFire;   // first execution cycle of the chosen station
    logic finishFire;  // last execution cycle: register the result
    logic retireFire;  // writeback cycle: release the station
  } rsuStrobe_t;

endpackage

// File: rtl/rsu_ctrl.sv
module rsu_ctrl
  import rsu_pkg::*;
#(
  parameter int NUM_STATIONS = 3,
  parameter int AGE_W        = 8,
  parameter int LATENCY      = 2,
  localparam int IDX_W = (NUM_STATIONS > 1) ? $clog2(NUM_STATIONS) : 1,
  localparam int CNT_W = $clog2(LATENCY + 1)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                allocValid,
  input  logic [NUM_STATIONS-1:0]             validVec,
  input  logic [NUM_STATIONS-1:0]             readyVec,
  input  logic [NUM_STATIONS-1:0][AGE_W-1:0]  ageVec,
  output logic                                allocReady,
  output logic [IDX_W-1:0]                    allocIdx,
  output logic [IDX_W-1:0]                    issueIdx,
  output logic [IDX_W-1:0]                    retireIdx,
  output logic                                wbActive,
  output rsuStrobe_t                          strobe
);

  logic             busy;
  logic [CNT_W-1:0] execCnt;
  logic [IDX_W-1:0] curIdx;
  logic             anyReady;
  logic [AGE_W-1:0] bestAge;
  logic [AGE_W-1:0] ageDiff;
  logic             unitIdle;
  logic             lastExec;

  // Lowest-numbered free station wins the allocation.
  always_comb begin
    allocIdx   = '0;
    allocReady = 1'b0;
    for (int i = NUM_STATIONS - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        allocIdx   = IDX_W'(i);
        allocReady = 1'b1;
      end
    end
  end

  // Oldest ready station: wrap-aware comparison of dispatch stamps.
  always_comb begin
    anyReady = 1'b0;
    issueIdx = '0;
    bestAge  = '0;
    ageDiff  = '0;
    for (int i = 0; i < NUM_STATIONS; i++) begin
      ageDiff = ageVec[i] - bestAge;
      if (readyVec[i] && (!anyReady || ageDiff[AGE_W-1])) begin
        anyReady = 1'b1;
        issueIdx = IDX_W'(i);
        bestAge  = ageVec[i];
      end
    end
  end

  // The unit is held from the first execution cycle through writeback.
  assign unitIdle = !busy && !wbActive;
  assign lastExec = busy && (execCnt == CNT_W'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      execCnt  <= '0;
      curIdx   <= '0;
      wbActive <= 1'b0;
    end else begin
      wbActive <= lastExec;
      if (unitIdle && anyReady) begin
        busy    <= 1'b1;
        execCnt <= CNT_W'(1);
        curIdx  <= issueIdx;
      end else if (lastExec) begin
        busy    <= 1'b0;
        execCnt <= '0;
      end else if (busy) begin
        execCnt <= execCnt + CNT_W'(1);
      end
    end
  end

  assign retireIdx = curIdx;

  always_comb begin
    strobe.allocFire  = allocValid && allocReady;
    strobe.issueFire  = unitIdle && anyReady;
    strobe.finishFire = lastExec;
    strobe.retireFire = wbActive;
  end

endmodule

// File: rtl/rsu_datapath.sv
module rsu_datapath
  import rsu_pkg::*;
#(
  parameter rsuOp_e OP_KIND   = OP_ADD,
  parameter int NUM_STATIONS  = 3,
  parameter int DATA_W        = 16,
  parameter int TAG_W         = 3,
  parameter int TAG_BASE      = 1,
  parameter int AGE_W         = 8,
  localparam int IDX_W = (NUM_STATIONS > 1) ? $clog2(NUM_STATIONS) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  rsuStrobe_t                          strobe,
  input  logic [IDX_W-1:0]                    allocIdx,
  input  logic [IDX_W-1:0]                    issueIdx,
  input  logic [IDX_W-1:0]                    retireIdx,
  input  logic                                allocAValid,
  input  logic [TAG_W-1:0]                    allocATag,
  input  logic [DATA_W-1:0]                   allocAValue,
  input  logic                                allocBValid,
  input  logic [TAG_W-1:0]                    allocBTag,
  input  logic [DATA_W-1:0]                   allocBValue,
  input  logic                                bus0Valid,
  input  logic [TAG_W-1:0]                    bus0Tag,
  input  logic [DATA_W-1:0]                   bus0Value,
  input  logic                                bus1Valid,
  input  logic [TAG_W-1:0]                    bus1Tag,
  input  logic [DATA_W-1:0]                   bus1Value,
  output logic [NUM_STATIONS-1:0]             validVec,
  output logic [NUM_STATIONS-1:0]             readyVec,
  output logic [NUM_STATIONS-1:0][AGE_W-1:0]  ageVec,
  output logic [TAG_W-1:0]                    wbTag,
  output logic [DATA_W-1:0]                   wbValue
);

  logic [AGE_W-1:0]                        seqCnt;
  logic [NUM_STATIONS-1:0][DATA_W-1:0]     entAVal;
  logic [NUM_STATIONS-1:0][DATA_W-1:0]     entBVal;
  logic [DATA_W-1:0]                       opA;
  logic [DATA_W-1:0]                       opB;
  logic [TAG_W-1:0]                        unitTag;
  logic [DATA_W-1:0]                       result;

  function automatic logic snoopHit(input logic [TAG_W-1:0] t);
    return (bus0Valid && (bus0Tag == t)) || (bus1Valid && (bus1Tag == t));
  endfunction

  function automatic logic [DATA_W-1:0] snoopVal(input logic [TAG_W-1:0] t);
    return (bus0Valid && (bus0Tag == t)) ? bus0Value : bus1Value;
  endfunction

  // Dispatch sequence stamp.
  always_ff @(posedge clk) begin
    if (!rstN)                 seqCnt <= '0;
    else if (strobe.allocFire) seqCnt <= seqCnt + AGE_W'(1);
  end

  for (genvar g = 0; g < NUM_STATIONS; g++) begin : gStation
    logic              stValid;
    logic              stIssued;
    logic              aV;
    logic              bV;
    logic [TAG_W-1:0]  aTag;
    logic [TAG_W-1:0]  bTag;
    logic [DATA_W-1:0] aVal;
    logic [DATA_W-1:0] bVal;
    logic [AGE_W-1:0]  stAge;
    logic              allocHere;

    assign allocHere = strobe.allocFire && (allocIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stValid  <= 1'b0;
        stIssued <= 1'b0;
        aV       <= 1'b0;
        bV       <= 1'b0;
        aTag     <= '0;
        bTag     <= '0;
        aVal     <= '0;
        bVal     <= '0;
        stAge    <= '0;
      end else if (allocHere) begin
        stValid  <= 1'b1;
        stIssued <= 1'b0;
        stAge    <= seqCnt;
        aTag     <= allocATag;
        bTag     <= allocBTag;
        aV       <= allocAValid || snoopHit(allocATag);
        bV       <= allocBValid || snoopHit(allocBTag);
        aVal     <= allocAValid ? allocAValue : snoopVal(allocATag);
        bVal     <= allocBValid ? allocBValue : snoopVal(allocBTag);
      end else begin
        if (strobe.retireFire && (retireIdx == IDX_W'(g))) stValid  <= 1'b0;
        if (strobe.issueFire && (issueIdx == IDX_W'(g)))   stIssued <= 1'b1;
        if (stValid && !aV && snoopHit(aTag)) begin
          aV   <= 1'b1;
          aVal <= snoopVal(aTag);
        end
        if (stValid && !bV && snoopHit(bTag)) begin
          bV   <= 1'b1;
          bVal <= snoopVal(bTag);
        end
      end
    end

    assign validVec[g] = stValid;
    assign readyVec[g] = stValid && !stIssued && aV && bV;
    assign ageVec[g]   = stAge;
    assign entAVal[g]  = aVal;
    assign entBVal[g]  = bVal;
  end

  // Operand latch for the non-pipelined unit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA     <= '0;
      opB     <= '0;
      unitTag <= '0;
    end else if (strobe.issueFire) begin
      opA     <= entAVal[issueIdx];
      opB     <= entBVal[issueIdx];
      unitTag <= TAG_W'(TAG_BASE) + TAG_W'(issueIdx);
    end
  end

  if (OP_KIND == OP_MUL) begin : gMul
    assign result = opA * opB;
  end else begin : gAdd
    assign result = opA + opB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbTag   <= '0;
      wbValue <= '0;
    end else if (strobe.finishFire) begin
      wbTag   <= unitTag;
      wbValue <= result;
    end
  end

endmodule

// File: rtl/rs_bank_unit.sv
module rs_bank_unit
  import rsu_pkg::*;
#(
  parameter rsuOp_e OP_KIND  = OP_ADD,
  parameter int NUM_STATIONS = 3,
  parameter int DATA_W       = 16,
  parameter int TAG_W        = 3,
  parameter int TAG_BASE     = 1,
  parameter int AGE_W        = 8,
  parameter int LATENCY      = (OP_KIND == OP_MUL) ? 3 : 2,
  localparam int IDX_W = (NUM_STATIONS > 1) ? $clog2(NUM_STATIONS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic              allocAValid,
  input  logic [TAG_W-1:0]  allocATag,
  input  logic [DATA_W-1:0] allocAValue,
  input  logic              allocBValid,
  input  logic [TAG_W-1:0]  allocBTag,
  input  logic [DATA_W-1:0] allocBValue,
  output logic              allocReady,
  output logic [TAG_W-1:0]  allocTag,
  input  logic              bus0Valid,
  input  logic [TAG_W-1:0]  bus0Tag,
  input  logic [DATA_W-1:0] bus0Value,
  input  logic              bus1Valid,
  input  logic [TAG_W-1:0]  bus1Tag,
  input  logic [DATA_W-1:0] bus1Value,
  output logic              wbValid,
  output logic [TAG_W-1:0]  wbTag,
  output logic [DATA_W-1:0] wbValue
);

  rsuStrobe_t                         strobe;
  logic [IDX_W-1:0]                   allocIdx;
  logic [IDX_W-1:0]                   issueIdx;
  logic [IDX_W-1:0]                   retireIdx;
  logic [NUM_STATIONS-1:0]            validVec;
  logic [NUM_STATIONS-1:0]            readyVec;
  logic [NUM_STATIONS-1:0][AGE_W-1:0] ageVec;

  rsu_ctrl #(
    .NUM_STATIONS(NUM_STATIONS),
    .AGE_W       (AGE_W),
    .LATENCY     (LATENCY)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .allocValid(allocValid),
    .validVec  (validVec),
    .readyVec  (readyVec),
    .ageVec    (ageVec),
    .allocReady(allocReady),
    .allocIdx  (allocIdx),
    .issueIdx  (issueIdx),
    .retireIdx (retireIdx),
    .wbActive  (wbValid),
    .strobe    (strobe)
  );

  rsu_datapath #(
    .OP_KIND     (OP_KIND),
    .NUM_STATIONS(NUM_STATIONS),
    .DATA_W      (DATA_W),
    .TAG_W       (TAG_W),
    .TAG_BASE    (TAG_BASE),
    .AGE_W       (AGE_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .allocIdx   (allocIdx),
    .issueIdx   (issueIdx),
    .retireIdx  (retireIdx),
    .allocAValid(allocAValid),
    .allocATag  (allocATag),
    .allocAValue(allocAValue),
    .allocBValid(allocBValid),
    .allocBTag  (allocBTag),
    .allocBValue(allocBValue),
    .bus0Valid  (bus0Valid),
    .bus0Tag    (bus0Tag),
    .bus0Value  (bus0Value),
    .bus1Valid  (bus1Valid),
    .bus1Tag    (bus1Tag),
    .bus1Value  (bus1Value),
    .validVec   (validVec),
    .readyVec   (readyVec),
    .ageVec     (ageVec),
    .wbTag      (wbTag),
    .wbValue    (wbValue)
  );

  assign allocTag = TAG_W'(TAG_BASE) + TAG_W'(allocIdx);

endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter int NUM_STATIONS = 3,
  parameter int TAG_W        = 3,
  parameter int TAG_BASE     = 1,
  parameter int LATENCY      = 2,
  localparam int OCC_W = $clog2(NUM_STATIONS + 1) + 1,
  localparam int GAP_W = $clog2(LATENCY + 2) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic             wbValid,
  input logic [TAG_W-1:0] wbTag
);

  logic [OCC_W-1:0] occ;
  logic [GAP_W-1:0] sinceWb;
  logic             seenWb;

  // Occupancy seen from the ports: +1 per accepted allocation, -1 after each writeback.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ <= '0;
    end else begin
      case ({allocValid && allocReady, wbValid})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceWb <= '0;
      seenWb  <= 1'b0;
    end else if (wbValid) begin
      sinceWb <= GAP_W'(1);
      seenWb  <= 1'b1;
    end else if (sinceWb < GAP_W'(LATENCY + 1)) begin
      sinceWb <= sinceWb + GAP_W'(1);
    end
  end

  AST_READY_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rstN)
    allocReady == (occ < OCC_W'(NUM_STATIONS))); // R2

  AST_WB_TAG_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbTag >= TAG_W'(TAG_BASE)) && (wbTag <= TAG_W'(TAG_BASE + NUM_STATIONS - 1))); // R3

  AST_WB_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (occ != '0)); // R4

  AST_WB_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid); // R4

  AST_UNIT_NOT_PIPELINED: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && seenWb) |-> (sinceWb >= GAP_W'(LATENCY + 1))); // R5

  AST_FREE_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> allocReady); // R10

endmodule

bind rs_bank_unit rsu_checker #(
  .NUM_STATIONS(NUM_STATIONS),
  .TAG_W       (TAG_W),
  .TAG_BASE    (TAG_BASE),
  .LATENCY     (LATENCY)
) u_rsuChecker (
  .clk       (clk),
  .rstN      (rstN),
  .allocValid(allocValid),
  .allocReady(allocReady),
  .wbValid   (wbValid),
  .wbTag     (wbTag)
);

// File: tb/rs_bank_unit_bench.sv
`timescale 1ns/1ps
module rs_bank_unit_bench;
  import rsu_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValidAdd = 1'b0, allocValidMul = 1'b0;
  logic        allocAValid = 1'b0, allocBValid = 1'b0;
  logic [2:0]  allocATag = '0, allocBTag = '0;
  logic [15:0] allocAValue = '0, allocBValue = '0;
  logic        bus0Valid = 1'b0, bus1Valid = 1'b0;
  logic [2:0]  bus0Tag = '0, bus1Tag = '0;
  logic [15:0] bus0Value = '0, bus1Value = '0;

  logic        aReady, mReady, aWbValid, mWbValid;
  logic [2:0]  aTag, mTag, aWbTag, mWbTag;
  logic [15:0] aWbValue, mWbValue;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rs_bank_unit u_rs_bank_unit (
    .clk(clk), .rstN(rstN), .allocValid(allocValidAdd),
    .allocAValid(allocAValid), .allocATag(allocATag), .allocAValue(allocAValue),
    .allocBValid(allocBValid), .allocBTag(allocBTag), .allocBValue(allocBValue),
    .allocReady(aReady), .allocTag(aTag),
    .bus0Valid(bus0Valid), .bus0Tag(bus0Tag), .bus0Value(bus0Value),
    .bus1Valid(bus1Valid), .bus1Tag(bus1Tag), .bus1Value(bus1Value),
    .wbValid(aWbValid), .wbTag(aWbTag), .wbValue(aWbValue));

  rs_bank_unit #(.OP_KIND(OP_MUL), .TAG_BASE(4)) u_rs_bank_unit_mul (
    .clk(clk), .rstN(rstN), .allocValid(allocValidMul),
    .allocAValid(allocAValid), .allocATag(allocATag), .allocAValue(allocAValue),
    .allocBValid(allocBValid), .allocBTag(allocBTag), .allocBValue(allocBValue),
    .allocReady(mReady), .allocTag(mTag),
    .bus0Valid(bus0Valid), .bus0Tag(bus0Tag), .bus0Value(bus0Value),
    .bus1Valid(bus1Valid), .bus1Tag(bus1Tag), .bus1Value(bus1Value),
    .wbValid(mWbValid), .wbTag(mWbTag), .wbValue(mWbValue));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Move to the middle of the next cycle and drop every input to idle.
  task automatic nextCycle();
    @(negedge clk);
    allocValidAdd = 1'b0; allocValidMul = 1'b0;
    allocAValid = 1'b0; allocBValid = 1'b0;
    bus0Valid = 1'b0; bus1Valid = 1'b0;
  endtask

  task automatic setOps(input bit av, input int at, input int aval,
                        input bit bv, input int bt, input int bval);
    allocAValid = av; allocATag = 3'(at); allocAValue = 16'(aval);
    allocBValid = bv; allocBTag = 3'(bt); allocBValue = 16'(bval);
  endtask

  task automatic expectWb(input bit mul, input int tag, input int val, input string req);
    logic v; logic [2:0] t; logic [15:0] d;
    v = mul ? mWbValid : aWbValid;
    t = mul ? mWbTag : aWbTag;
    d = mul ? mWbValue : aWbValue;
    check(v == 1'b1, req, "wbValid", int'(v), 1);
    check(int'(t) == tag, req, "wbTag", int'(t), tag);
    check(int'(d) == val, req, "wbValue", int'(d), val);
  endtask

  task automatic expectIdle(input bit mul, input string req);
    logic v;
    v = mul ? mWbValid : aWbValid;
    check(v == 1'b0, req, "wbValid idle", int'(v), 0);
  endtask

  task automatic idleThenWb(input bit mul, input int n, input int tag,
                            input int val, input string req);
    for (int k = 1; k <= n; k++) begin
      nextCycle();
      if (k < n) expectIdle(mul, req);
      else       expectWb(mul, tag, val, req);
    end
  endtask

  task automatic testReset();
    check(aReady == 1'b1, "R1", "adder allocReady", int'(aReady), 1);
    check(int'(aTag) == 1, "R1", "adder allocTag", int'(aTag), 1);
    check(mReady == 1'b1, "R1", "mul allocReady", int'(mReady), 1);
    check(int'(mTag) == 4, "R1", "mul allocTag", int'(mTag), 4);
    expectIdle(1'b0, "R1");
    expectIdle(1'b1, "R1");
  endtask

  // Operands ready at dispatch; add latency and wrap.
  task automatic testAddBasic();
    nextCycle();
    setOps(1, 0, 5, 1, 0, 7); allocValidAdd = 1'b1;
    idleThenWb(1'b0, 3, 1, 12, "R3 R4");
    check(int'(aTag) == 2, "R10", "station busy during W", int'(aTag), 2);
    nextCycle();
    check(int'(aTag) == 1, "R10", "station free after W", int'(aTag), 1);
    setOps(1, 0, 16'hFFFF, 1, 0, 2); allocValidAdd = 1'b1;
    idleThenWb(1'b0, 3, 1, 1, "R12 add wrap");
    nextCycle();
  endtask

  // Multiply latency, low-half product and back-to-back non-pipelined spacing.
  task automatic testMul();
    nextCycle();
    setOps(1, 0, 300, 1, 0, 300); allocValidMul = 1'b1;
    nextCycle();
    check(int'(mTag) == 5, "R2", "mul next station", int'(mTag), 5);
    setOps(1, 0, 16'hFFFF, 1, 0, 3); allocValidMul = 1'b1;
    idleThenWb(1'b1, 3, 4, 24464, "R4 R12 mul");
    idleThenWb(1'b1, 4, 5, 16'hFFFD, "R5 R12 mul");
    nextCycle();
  endtask

  // Fill all stations, ignored request when full, then serial drain.
  task automatic testFull();
    for (int s = 0; s < 3; s++) begin
      nextCycle();
      check(int'(aTag) == s + 1, "R2", "lowest free station", int'(aTag), s + 1);
      setOps(0, 7, 0, 1, 0, s + 1); allocValidAdd = 1'b1;
    end
    nextCycle();
    check(aReady == 1'b0, "R2", "allocReady when full", int'(aReady), 0);
    setOps(1, 0, 100, 1, 0, 100); allocValidAdd = 1'b1;
    nextCycle();
    expectIdle(1'b0, "R2");
    bus0Valid = 1'b1; bus0Tag = 3'd7; bus0Value = 16'd10;
    idleThenWb(1'b0, 3, 1, 11, "R7 R2");
    check(aReady == 1'b0, "R10", "full during W", int'(aReady), 0);
    nextCycle();
    check(aReady == 1'b1 && int'(aTag) == 1, "R10", "freed station tag", int'(aTag), 1);
    expectIdle(1'b0, "R5");
    idleThenWb(1'b0, 2, 2, 12, "R5");
    idleThenWb(1'b0, 3, 3, 13, "R5");
    nextCycle();
  endtask

  // Younger entry in a lower station loses to an older one.
  task automatic testOldest();
    nextCycle();
    setOps(1, 0, 1, 1, 0, 1); allocValidAdd = 1'b1;
    nextCycle();
    setOps(0, 6, 0, 1, 0, 20); allocValidAdd = 1'b1;
    nextCycle(); expectIdle(1'b0, "R6");
    nextCycle(); expectWb(1'b0, 1, 2, "R3");
    check(int'(aTag) == 3, "R10", "next free during W", int'(aTag), 3);
    nextCycle();
    check(int'(aTag) == 1, "R10", "reuse after W", int'(aTag), 1);
    setOps(0, 6, 0, 1, 0, 30); allocValidAdd = 1'b1;
    nextCycle();
    bus1Valid = 1'b1; bus1Tag = 3'd6; bus1Value = 16'd100;
    idleThenWb(1'b0, 3, 2, 120, "R6 R7 oldest first");
    idleThenWb(1'b0, 3, 1, 130, "R6");
    nextCycle();
  endtask

  // Both buses in one cycle, and a broadcast during allocation.
  task automatic testDualBus();
    nextCycle();
    setOps(0, 5, 0, 0, 6, 0); allocValidAdd = 1'b1;
    nextCycle();
    bus0Valid = 1'b1; bus0Tag = 3'd5; bus0Value = 16'd3;
    bus1Valid = 1'b1; bus1Tag = 3'd6; bus1Value = 16'd4;
    idleThenWb(1'b0, 3, 1, 7, "R8");
    nextCycle();
    setOps(0, 5, 0, 1, 0, 1); allocValidAdd = 1'b1;
    bus0Valid = 1'b1; bus0Tag = 3'd5; bus0Value = 16'd9;
    idleThenWb(1'b0, 3, 1, 10, "R9");
    nextCycle();
  endtask

  // Unrelated tags must not wake the waiting entry.
  task automatic testMismatch();
    nextCycle();
    setOps(0, 5, 0, 1, 0, 2); allocValidAdd = 1'b1;
    nextCycle();
    bus0Valid = 1'b1; bus0Tag = 3'd6; bus0Value = 16'd50;
    bus1Valid = 1'b1; bus1Tag = 3'd4; bus1Value = 16'd60;
    for (int k = 0; k < 5; k++) begin
      nextCycle(); expectIdle(1'b0, "R11");
    end
    nextCycle();
    expectIdle(1'b0, "R11");
    bus0Valid = 1'b1; bus0Tag = 3'd5; bus0Value = 16'd40;
    idleThenWb(1'b0, 3, 1, 42, "R11 R7");
    nextCycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddBasic();
    testMul();
    testFull();
    testOldest();
    testDualBus();
    testMismatch();
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule